// File: doc/BRIEF.md
# Reset-Time Debug Entry and Bus Clock Selector

This controller settles two things once, when power-on reset ends. It decides whether the device starts in a serial debug monitor or in normal operation. It also decides how the bus clock is obtained from the incoming clock. It bases that choice on four inputs:

- the two bytes stored at the top of memory where the reset vector lives;
- an encoded voltage level on the interrupt pin;
- one strap pin on a port.

The decision is captured once and held. It is presented as the mode, a PLL enable with its multiplication factor, and a clock source select. The block also produces a one-cycle bus-clock enable at the chosen rate.

Every valid combination of inputs is meant to give a bus rate that suits 9600-baud serial traffic. The rates work out as follows:

- An erased vector lets the debug mode start from a plain supply-high level on the interrupt pin.
- An erased vector with the interrupt pin grounded starts the debug mode with the PLL raising a 32.768 kHz crystal by 75.
- A programmed vector needs the high-voltage test level on the interrupt pin. The strap pin then picks a half or quarter rate.

The PLL circuit and the analog level detector are outside this block. The serial protocol is also outside it.

Top module: `reset_mode_ctrl`

## Requirements
- R1: The vector counts as erased only when `vec_hi` and `vec_lo` both equal 0xFF. A vector with only one byte at 0xFF counts as programmed.
- R2: A programmed vector with `irq_lvl` = 2'b10 (test level) gives the debug mode with the PLL off. `strap` = 0 then gives `div_sel` = 2'b00 (half rate), and `strap` = 1 gives `div_sel` = 2'b01 (quarter rate).
- R3: An erased vector with `irq_lvl` = 2'b01 (supply-high) gives the debug mode with the PLL off and `div_sel` = 2'b00, whatever the strap.
- R4: An erased vector with `irq_lvl` = 2'b00 (ground) gives the debug mode with `pll_en` = 1, `pll_mult` = 75 and `div_sel` = 2'b10, whatever the strap.
- R5: A programmed vector with `irq_lvl` = 2'b00 or 2'b01 gives normal mode (`mon_mode` = 0), `pll_en` = 0 and `div_sel` = 2'b00. The PLL is never enabled with a programmed vector.
- R6: `irq_lvl` = 2'b11 (invalid) gives normal mode, the PLL off and `div_sel` = 2'b00, for any vector and any strap.
- R7: An erased vector with `irq_lvl` = 2'b10 gives the debug mode with the PLL off. The strap picks the divider as in R2.
- R8: The inputs are captured on the first rising clock edge at which `rst_n` is high. Any later change of `vec_hi`, `vec_lo`, `irq_lvl` or `strap` leaves all outputs unchanged until the next reset.
- R9: While `rst_n` is low, and until the capture edge, the outputs read as follows: `mon_mode` = 0, `pll_en` = 0, `pll_mult` = 0, `div_sel` = 2'b00 and `bus_en` = 0. `pll_mult` is 0 whenever `pll_en` is 0.
- R10: Number the capture edge 0. After edge j, `bus_en` is high exactly when (j+1) mod N = 0, where N is 2 for `div_sel` 2'b00, 4 for 2'b01 and 1 for 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock (the PLL output when the PLL path is chosen) |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_hi | input | 8 | Reset-vector byte at the upper address |
| vec_lo | input | 8 | Reset-vector byte at the lower address |
| irq_lvl | input | 2 | Interrupt-pin level code: 00 ground, 01 supply-high, 10 test level, 11 invalid |
| strap | input | 1 | Port strap pin choosing half or quarter rate at test level |
| mon_mode | output | 1 | 1 = debug monitor mode, 0 = normal mode |
| pll_en | output | 1 | Enables the PLL |
| pll_mult | output | 7 | PLL multiplication factor, 0 when the PLL is off |
| div_sel | output | 2 | Clock source: 00 half, 01 quarter, 10 PLL direct |
| bus_en | output | 1 | One-cycle bus-clock enable |

## Verification
A fault in the decision table or in the vector compare shows up at the first sample after the capture edge, as a wrong `mon_mode`, `pll_en` or `div_sel`. A latch that keeps tracking its inputs gives itself away a few cycles later, once the pins are disturbed after release. A wrong divider count, or a counter that does not restart, moves the first `bus_en` pulse or changes its spacing. That error appears within the first four cycles after capture. Sweeping the erased and programmed vectors, all four level codes and both strap values reaches every row of the decision table.

// File: rtl/reset_mode_pkg.sv
// Shared types for the reset-time debug entry controller.
package reset_mode_pkg;

    // Encoded interrupt-pin level from the analog detector.
    typedef enum logic [1:0] {
        LVL_GND  = 2'b00,
        LVL_VDD  = 2'b01,
        LVL_TEST = 2'b10,
        LVL_BAD  = 2'b11
    } irq_lvl_e;

    // Bus clock source select.
    typedef enum logic [1:0] {
        SRC_HALF    = 2'b00,
        SRC_QUARTER = 2'b01,
        SRC_PLL     = 2'b10
    } clk_src_e;

    // Full entry decision.
    typedef struct packed {
        logic     mon;
        logic     pll;
        clk_src_e src;
    } entry_cfg_t;

    localparam entry_cfg_t CFG_NORMAL = '{mon: 1'b0, pll: 1'b0, src: SRC_HALF};

endpackage

// File: rtl/vec_blank_chk.sv
// vec_blank_chk: flags an erased reset vector.
// Assumes an erased byte reads as all ones; every byte must be erased.
module vec_blank_chk #(
    parameter int VEC_BYTES = 2,
    localparam int VW = VEC_BYTES * 8
) (
    input  logic [VW-1:0] vec,
    output logic          blank
);
    logic [VEC_BYTES-1:0] byte_erased;

    // One compare per byte.
    for (genvar g = 0; g < VEC_BYTES; g++) begin : g_byte
        assign byte_erased[g] = (vec[g*8 +: 8] == 8'hFF);
    end

    // Erased only if all bytes are erased.
    assign blank = &byte_erased;
endmodule

// File: rtl/entry_decide.sv
// entry_decide: combinational decision table for mode, PLL and clock source.
// Assumes the level code is already resolved from the analog detector.
module entry_decide
    import reset_mode_pkg::*;
(
    input  logic       blank,
    input  irq_lvl_e   lvl,
    input  logic       strap,
    output entry_cfg_t cfg
);
    // Map (blank, level, strap) to a configuration.
    always_comb begin
        cfg = CFG_NORMAL;
        unique case (lvl)
            LVL_TEST: begin
                cfg.mon = 1'b1;
                cfg.src = strap ? SRC_QUARTER : SRC_HALF;
            end
            LVL_VDD: begin
                if (blank) cfg.mon = 1'b1;
            end
            LVL_GND: begin
                if (blank) begin
                    cfg.mon = 1'b1;
                    cfg.pll = 1'b1;
                    cfg.src = SRC_PLL;
                end
            end
            default: cfg = CFG_NORMAL;
        endcase
    end

    // R5: the PLL is never chosen for a programmed vector.
    always_comb begin
        pll_needs_blank_chk: assert (!(cfg.pll && !blank));
    end
endmodule

// File: rtl/cfg_latch.sv
// cfg_latch: captures the decision on the first clock with reset released,
// then holds it until the next reset. Assumes synchronous active-low reset.
module cfg_latch
    import reset_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  entry_cfg_t cfg_in,
    output entry_cfg_t cfg_q,
    output logic       cap_q
);
    // Capture once per reset, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_NORMAL;
            cap_q <= 1'b0;
        end else if (!cap_q) begin
            cfg_q <= cfg_in;
            cap_q <= 1'b1;
        end
    end

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q |=> $stable(cfg_q));
endmodule

// File: rtl/bus_div.sv
// bus_div: makes a one-cycle bus-clock enable at 1/N of the input clock.
// Counting starts from zero on the capture edge; idle while run is low.
module bus_div
    import reset_mode_pkg::*;
#(
    parameter int DIV_LO = 2,
    parameter int DIV_HI = 4,
    localparam int CW = (DIV_HI > 1) ? $clog2(DIV_HI) : 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  clk_src_e src,
    output logic     bus_en
);
    localparam logic [CW-1:0] TERM_LO = CW'(DIV_LO - 1);
    localparam logic [CW-1:0] TERM_HI = CW'(DIV_HI - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] term;

    // Terminal count for the selected source.
    always_comb begin
        unique case (src)
            SRC_HALF:    term = TERM_LO;
            SRC_QUARTER: term = TERM_HI;
            default:     term = '0;
        endcase
    end

    // Free-running modulo counter, cleared until capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt >= term) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign bus_en = run && (cnt == term);

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= term));
    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && src != SRC_PLL) |=> !bus_en);
endmodule

// File: rtl/reset_mode_ctrl.sv
// reset_mode_ctrl: top of the reset-time debug entry controller.
// Assumes inputs are stable around reset release; holds the decision until the next reset.
module reset_mode_ctrl
    import reset_mode_pkg::*;
#(
    parameter int DIV_LO   = 2,
    parameter int DIV_HI   = 4,
    parameter int MULT_W   = 7,
    parameter int PLL_MULT = 75
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        vec_hi,
    input  logic [7:0]        vec_lo,
    input  logic [1:0]        irq_lvl,
    input  logic              strap,
    output logic              mon_mode,
    output logic              pll_en,
    output logic [MULT_W-1:0] pll_mult,
    output logic [1:0]        div_sel,
    output logic              bus_en
);
    logic       blank;
    entry_cfg_t cfg_d;
    entry_cfg_t cfg_q;
    logic       cap_q;

    vec_blank_chk #(.VEC_BYTES(2)) u_blank (
        .vec   ({vec_hi, vec_lo}),
        .blank (blank)
    );

    entry_decide u_decide (
        .blank (blank),
        .lvl   (irq_lvl_e'(irq_lvl)),
        .strap (strap),
        .cfg   (cfg_d)
    );

    cfg_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_d),
        .cfg_q  (cfg_q),
        .cap_q  (cap_q)
    );

    bus_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cap_q),
        .src    (cfg_q.src),
        .bus_en (bus_en)
    );

    // Drive the held decision onto the ports.
    assign mon_mode = cfg_q.mon;
    assign pll_en   = cfg_q.pll;
    assign div_sel  = cfg_q.src;
    assign pll_mult = cfg_q.pll ? MULT_W'(PLL_MULT) : '0;

    // R4
    pll_implies_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> mon_mode);
    // R9
    idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_q |-> !bus_en);
endmodule

// File: tb/reset_mode_ctrl_bench.sv
module reset_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] vec_hi = 8'h00, vec_lo = 8'h00;
    logic [1:0] irq_lvl = 2'b00;
    logic       strap = 1'b0;
    logic       mon_mode, pll_en, bus_en;
    logic [6:0] pll_mult;
    logic [1:0] div_sel;

    int total = 0;
    int bad = 0;
    int pushed = 0;
    int popped = 0;

    typedef struct {
        logic     mon;
        logic     pll;
        logic [1:0] sel;
        int       n;
        string    req;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    reset_mode_ctrl u_reset_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .vec_hi(vec_hi), .vec_lo(vec_lo),
        .irq_lvl(irq_lvl), .strap(strap), .mon_mode(mon_mode), .pll_en(pll_en),
        .pll_mult(pll_mult), .div_sel(div_sel), .bus_en(bus_en)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: applies one combination and pushes the expected decision.
    task automatic run_case(bit blank, logic [1:0] lvl, bit s, bit alt);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0;
        if (blank) begin
            vec_hi = 8'hFF;
            vec_lo = 8'hFF;
        end else if (alt) begin
            vec_hi = 8'hFF;
            vec_lo = 8'h3C;
        end else begin
            vec_hi = 8'hA5;
            vec_lo = 8'hFF;
        end
        irq_lvl = lvl;
        strap = s;
        e.mon = 1'b0; e.pll = 1'b0; e.sel = 2'b00; e.n = 2; e.req = "R5";
        if (lvl == 2'b11) e.req = "R6";
        else if (lvl == 2'b10) begin
            e.mon = 1'b1;
            e.sel = s ? 2'b01 : 2'b00;
            e.n = s ? 4 : 2;
            e.req = blank ? "R7" : "R2";
        end else if (blank && lvl == 2'b01) begin
            e.mon = 1'b1;
            e.req = "R3";
        end else if (blank && lvl == 2'b00) begin
            e.mon = 1'b1; e.pll = 1'b1; e.sel = 2'b10; e.n = 1;
            e.req = "R4";
        end
        if (!blank && lvl != 2'b10 && lvl != 2'b11) e.req = "R1";
        q.push_back(e);
        pushed++;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "mon_mode in reset", int'(mon_mode), 0);
        chk("R9", "pll_en in reset", int'(pll_en), 0);
        chk("R9", "pll_mult in reset", int'(pll_mult), 0);
        chk("R9", "div_sel in reset", int'(div_sel), 0);
        chk("R9", "bus_en in reset", int'(bus_en), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R8: disturb every input after capture
        vec_hi = ~vec_hi;
        vec_lo = ~vec_lo;
        irq_lvl = ~irq_lvl;
        strap = ~strap;
        wait (popped == pushed);
    endtask

    // Monitor: pops the expected item and compares once the design has captured.
    initial begin
        forever begin
            exp_t e;
            wait (q.size() > 0);
            e = q[0];
            @(posedge rst_n);
            @(negedge clk);
            chk(e.req, "mon_mode", int'(mon_mode), int'(e.mon));
            chk(e.req, "pll_en", int'(pll_en), int'(e.pll));
            chk(e.req, "div_sel", int'(div_sel), int'(e.sel));
            chk("R9", "pll_mult", int'(pll_mult), e.pll ? 75 : 0);
            for (int j = 0; j < 8; j++) begin
                if (j > 0) @(negedge clk);
                // R10: enable spacing
                chk("R10", $sformatf("bus_en after edge %0d", j), int'(bus_en),
                    (((j + 1) % e.n) == 0) ? 1 : 0);
            end
            // R8: outputs held despite input changes
            chk("R8", "mon_mode held", int'(mon_mode), int'(e.mon));
            chk("R8", "pll_en held", int'(pll_en), int'(e.pll));
            chk("R8", "div_sel held", int'(div_sel), int'(e.sel));
            void'(q.pop_front());
            popped++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 4; c++)
                for (int s = 0; s < 2; s++)
                    run_case(bit'(b), 2'(c), bit'(s), bit'(c[0]));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule